// File: doc/BRIEF.md
# UART Autobaud Detector with Divisor Acknowledgement

This block sits at the receive end of a serial slave link that does not yet know its bit rate. After reset it watches the receive line for a single sync character, `@` (0x40). The character is sent LSB first in 8N1 framing, so it opens with a low span of exactly seven bit times: the start bit followed by six zero data bits. The block counts system clocks over that span. It rounds the count to the nearest multiple of 7 × 16 clocks and keeps the quotient as a 16-bit baud divisor for 16x oversampling. Because the divisor comes from the host's real timing, it is already scaled to whatever system clock is running.

Once the divisor is captured, the block raises its locked flag. It then sends a four-byte reply on its own 8N1 transmitter, using the new divisor for bit timing: first a fixed 0xBF header, then the divisor low byte, then the divisor high byte, then 0x00. A host-wait output stays high from reset until the last stop bit of that reply is complete, so the host knows when it may send the next data. A synchronous re-arm input drops the lock at any time, stops a reply that is in progress and starts a new search for the sync character.

Top module: `autobaud_ack`

## Requirements
- R1: While reset is held and just after it, host_wait is 1, locked is 0, tx_out is 1 (idle) and the divisor outputs read 0.
- R2: The divisor equals floor((N + 56) / 112), where N is the number of clocks the receive line stayed low. Reception uses LSB-first 8N1 framing, with start bit 0 and stop bit 1.
- R3: A low pulse on the receive line shorter than 16 clocks is dropped. It causes no lock and no transmission, and the search goes on. A pulse of exactly 16 clocks is accepted.
- R4: A computed divisor of 0 is raised to 1, so the divisor is never 0 while locked is 1.
- R5: After lock, tx_out sends four bytes back to back: 0xBF, divisor[7:0], divisor[15:8], 0x00. Each byte is framed as one start bit (0), eight data bits LSB first and one stop bit (1).
- R6: Every transmitted bit lasts exactly 16 × divisor clocks.
- R7: locked rises in the same edge that captures the divisor, before the first start bit of the reply. After that, locked and the divisor do not change until a re-arm.
- R8: host_wait falls on the clock edge that ends the last stop bit of the reply, exactly 40 × 16 × divisor clocks after the first start bit begins. It never falls while locked is 0.
- R9: re-arm takes effect on the next edge. It clears locked and the divisor, sets host_wait to 1, returns tx_out to idle and restarts the search. It takes priority over the reply finishing in the same cycle.
- R10: Once locked, further activity on the receive line changes neither the divisor nor tx_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rearm | input | 1 | Synchronous re-arm: drop the lock and search again |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| tx_out | output | 1 | Serial transmit line carrying the reply, idle high |
| div_lo | output | 8 | Measured baud divisor, low byte |
| div_hi | output | 8 | Measured baud divisor, high byte |
| locked | output | 1 | A sync character has been measured and the divisor is valid |
| host_wait | output | 1 | High while the host must hold off sending |

## Verification
Two events can land on the same clock edge: the reply finishing its last stop bit, which would release host_wait, and a re-arm request. The bench times the reply from its first start bit and drives re-arm so that it is sampled on exactly the edge that ends the final stop bit. It then expects host_wait to stay high and locked to be low. In every normal run, host_wait must still be high one cycle before that edge and low right after it. A second collision is also driven: a re-arm in the middle of a long reply with a divisor above 255. This must abort the transmission at once, and a fresh sync must still be measured correctly afterwards.

// File: rtl/abd_pkg.sv
// Package: shared constants and state type for the autobaud front end.
// Assumes 8N1 framing and 16x oversampling for the divisor.
package abd_pkg;
    localparam int OVS_LG        = 4;
    localparam int OVS           = 1 << OVS_LG;
    localparam int SYNC_LOW_BITS = 7;
    localparam int FRAME_BITS    = 10;
    localparam logic [7:0] ACK_HEAD = 8'hBF;
    localparam logic [7:0] ACK_TAIL = 8'h00;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_MEAS = 2'd1,
        ST_ACK  = 2'd2,
        ST_IDLE = 2'd3
    } abd_state_t;
endpackage

// File: rtl/abd_rx_sync.sv
// Module: brings the asynchronous receive line into the clock domain.
// Assumes the line idles high, so every stage resets to 1.
module abd_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_async,
    output logic rx_sync
);
    logic [STAGES-1:0] shreg;

    // Shift the line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '1;
        else        shreg <= {shreg[STAGES-2:0], rx_async};
    end

    assign rx_sync = shreg[STAGES-1];
endmodule

// File: rtl/abd_div_calc.sv
// Module: turns a low-span clock count into a rounded 16x divisor.
// Assumes CNT_W is wider than DIV_W. The result is clamped to 1..2^DIV_W-1.
module abd_div_calc
    import abd_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int DIV_W = 16
) (
    input  logic [CNT_W-1:0] low_cnt,
    output logic [DIV_W-1:0] divisor
);
    localparam int SPAN = SYNC_LOW_BITS * OVS;
    localparam logic [CNT_W:0] SPAN_C = (CNT_W+1)'(SPAN);
    localparam logic [CNT_W:0] HALF_C = (CNT_W+1)'(SPAN / 2);
    localparam logic [CNT_W:0] MAXD_C = (CNT_W+1)'({DIV_W{1'b1}});

    logic [CNT_W:0] biased;
    logic [CNT_W:0] quot;

    // Divide by the constant span with round-to-nearest, then clamp.
    always_comb begin
        biased = {1'b0, low_cnt} + HALF_C;
        quot   = biased / SPAN_C;
        if (quot == '0)          divisor = DIV_W'(1);
        else if (quot > MAXD_C)  divisor = {DIV_W{1'b1}};
        else                     divisor = quot[DIV_W-1:0];
    end
endmodule

// File: rtl/abd_ack_tx.sv
// Module: 8N1 transmitter that sends NBYTES payload bytes back to back.
// Assumes bit_len stays constant while busy and is at least 2.
// Byte 0 of the payload goes out first.
module abd_ack_tx
    import abd_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int TMR_W  = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  abort,
    input  logic                  start,
    input  logic [TMR_W-1:0]      bit_len,
    input  logic [8*NBYTES-1:0]   payload,
    output logic                  txd,
    output logic                  finish
);
    localparam int BI_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic             busy;
    logic [TMR_W-1:0] tmr;
    logic [3:0]       bit_i;
    logic [BI_W-1:0]  byte_i;
    logic [7:0]       bytes [NBYTES];
    logic [7:0]       cur;
    logic [2:0]       dsel;
    logic             frame_bit;
    logic             wrap;

    // Split the payload into individual bytes.
    for (genvar g = 0; g < NBYTES; g++) begin : g_bytes
        assign bytes[g] = payload[8*g +: 8];
    end

    // Choose the line level for the current frame position.
    always_comb begin
        cur  = bytes[byte_i];
        dsel = bit_i[2:0] - 3'd1;
        if (bit_i == 4'd0)                    frame_bit = 1'b0;
        else if (bit_i == 4'(FRAME_BITS - 1)) frame_bit = 1'b1;
        else                                  frame_bit = cur[dsel];
    end

    assign wrap   = busy && (tmr == bit_len - 1'b1);
    assign finish = wrap && (bit_i == 4'(FRAME_BITS - 1)) && (byte_i == BI_W'(NBYTES - 1));
    assign txd    = busy ? frame_bit : 1'b1;

    // Step the bit timer, the bit index and the byte index.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy   <= 1'b0;
            tmr    <= '0;
            bit_i  <= '0;
            byte_i <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                tmr    <= '0;
                bit_i  <= '0;
                byte_i <= '0;
            end
        end else if (wrap) begin
            tmr <= '0;
            if (bit_i == 4'(FRAME_BITS - 1)) begin
                bit_i <= '0;
                if (finish) busy <= 1'b0;
                else        byte_i <= byte_i + 1'b1;
            end else begin
                bit_i <= bit_i + 4'd1;
            end
        end else begin
            tmr <= tmr + 1'b1;
        end
    end
endmodule

// File: rtl/autobaud_ack.sv
// Module: measures the sync character's low span, captures the divisor and
// sends the four-byte acknowledgement. host_wait stays high until the
// acknowledgement is done. Assumes the host sends 0x40 in 8N1 framing.
module autobaud_ack
    import abd_pkg::*;
#(
    parameter int CNT_W   = 24,
    parameter int DIV_W   = 16,
    parameter int MIN_LOW = 16,
    parameter int SYNC_FF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rearm,
    input  logic       rx_in,
    output logic       tx_out,
    output logic [7:0] div_lo,
    output logic [7:0] div_hi,
    output logic       locked,
    output logic       host_wait
);
    localparam int TMR_W = DIV_W + OVS_LG;

    abd_state_t       state;
    logic             rx_s;
    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_new;
    logic             locked_q;
    logic             wait_q;
    logic             tx_start;
    logic             tx_finish;

    abd_rx_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk(clk), .rst_n(rst_n), .rx_async(rx_in), .rx_sync(rx_s)
    );

    abd_div_calc #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_div (
        .low_cnt(cnt), .divisor(div_new)
    );

    abd_ack_tx #(.NBYTES(4), .TMR_W(TMR_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .abort(rearm), .start(tx_start),
        .bit_len({div_q, OVS_LG'(0)}),
        .payload({ACK_TAIL, div_q[15:8], div_q[7:0], ACK_HEAD}),
        .txd(tx_out), .finish(tx_finish)
    );

    // Sequence through hunt, measure, acknowledge and idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HUNT;
            cnt      <= '0;
            div_q    <= '0;
            locked_q <= 1'b0;
            wait_q   <= 1'b1;
            tx_start <= 1'b0;
        end else begin
            tx_start <= 1'b0;
            if (rearm) begin
                state    <= ST_HUNT;
                cnt      <= '0;
                div_q    <= '0;
                locked_q <= 1'b0;
                wait_q   <= 1'b1;
            end else begin
                case (state)
                    ST_HUNT: if (!rx_s) begin
                        cnt   <= CNT_W'(1);
                        state <= ST_MEAS;
                    end
                    ST_MEAS: if (!rx_s) begin
                        if (cnt != {CNT_W{1'b1}}) cnt <= cnt + 1'b1;
                    end else if (cnt < CNT_W'(MIN_LOW)) begin
                        state <= ST_HUNT;
                    end else begin
                        div_q    <= div_new;
                        locked_q <= 1'b1;
                        tx_start <= 1'b1;
                        state    <= ST_ACK;
                    end
                    ST_ACK: if (tx_finish) begin
                        wait_q <= 1'b0;
                        state  <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign div_lo    = div_q[7:0];
    assign div_hi    = div_q[15:8];
    assign locked    = locked_q;
    assign host_wait = wait_q;
endmodule

// File: rtl/abd_chk.sv
// Module: assertion checker for autobaud_ack, attached by bind below.
module abd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rearm,
    input logic       tx_out,
    input logic [7:0] div_lo,
    input logic [7:0] div_hi,
    input logic       locked,
    input logic       host_wait
);
    // R4
    div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> ({div_hi, div_lo} != 16'd0));

    // R7
    div_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !rearm) |=> (locked && $stable({div_hi, div_lo})));

    // R8
    wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_wait) |-> locked);

    // R8
    wait_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> host_wait);

    // R5
    tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> tx_out);

    // R9
    rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (host_wait && !locked && tx_out && {div_hi, div_lo} == 16'd0));
endmodule

bind autobaud_ack abd_chk u_abd_chk (
    .clk(clk), .rst_n(rst_n), .rearm(rearm), .tx_out(tx_out),
    .div_lo(div_lo), .div_hi(div_hi), .locked(locked), .host_wait(host_wait)
);

// File: tb/autobaud_ack_test.sv
// Bench: sweeps low-span lengths and derives each divisor arithmetically.
// It decodes the reply at bit centres, checks when host_wait is released
// and drives re-arm into the collision cases.
module autobaud_ack_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, rearm, rx_in;
    logic       tx_out, locked, host_wait;
    logic [7:0] div_lo, div_hi;
    int total = 0;
    int bad   = 0;

    autobaud_ack uut (
        .clk(clk), .rst_n(rst_n), .rearm(rearm), .rx_in(rx_in),
        .tx_out(tx_out), .div_lo(div_lo), .div_hi(div_hi),
        .locked(locked), .host_wait(host_wait)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_div(input int n);
        int q = (n + 56) / 112;
        if (q < 1) q = 1;
        if (q > 65535) q = 65535;
        return q;
    endfunction

    task automatic drive_low(input int n);
        rx_in = 1'b0;
        repeat (n) @(negedge clk);
        rx_in = 1'b1;
    endtask

    task automatic do_rearm();
        rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_tx_fall(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (tx_out == 1'b0) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic quiet_watch(input int cycles, input string req);
        bit q = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            if (tx_out !== 1'b1) q = 1'b0;
            @(negedge clk);
        end
        chk(q, req, "tx_out stayed idle", q, 1);
    endtask

    task automatic check_ack(input int n, input bit rearm_end);
        int d = exp_div(n);
        int bl = 16 * d;
        logic [39:0] fr = '0;
        bit seen;
        bit st_ok = 1'b1;
        logic [7:0] eb;
        wait_tx_fall(seen);
        chk(seen, "R5", "reply start bit seen", seen, 1);
        chk(locked == 1'b1, "R7", "locked at first start bit", locked, 1);
        chk({div_hi, div_lo} == 16'(d), "R2",
            $sformatf("divisor for low count %0d", n), {div_hi, div_lo}, d);
        for (int c = 0; c < 40 * bl; c++) begin
            if (c % bl == bl / 2) fr[c / bl] = tx_out;
            if (c == bl - 1 && tx_out !== 1'b0) st_ok = 1'b0;
            if (c == bl && tx_out !== 1'b1) st_ok = 1'b0;
            if (c == 40 * bl - 1) begin
                chk(host_wait == 1'b1, "R8", "wait held before last edge", host_wait, 1);
                if (rearm_end) rearm = 1'b1;
            end
            @(negedge clk);
        end
        rearm = 1'b0;
        chk(st_ok, "R6", $sformatf("start bit is %0d clocks", bl), st_ok, 1);
        for (int j = 0; j < 4; j++) begin
            eb = (j == 0) ? 8'hBF : (j == 1) ? 8'(d) : (j == 2) ? 8'(d >> 8) : 8'h00;
            chk(fr[j*10] == 1'b0 && fr[j*10+9] == 1'b1 && fr[j*10+1 +: 8] == eb,
                "R5", $sformatf("reply byte %0d frame", j), fr[j*10 +: 10],
                {1'b1, eb, 1'b0});
        end
        if (rearm_end) begin
            chk(host_wait == 1'b1 && locked == 1'b0, "R9", "rearm beats release",
                {host_wait, locked}, 2'b10);
            chk({div_hi, div_lo} == 16'd0, "R9", "divisor cleared", {div_hi, div_lo}, 0);
        end else begin
            chk(host_wait == 1'b0, "R8", "wait released after last stop bit", host_wait, 0);
            chk(locked == 1'b1, "R7", "lock held after reply", locked, 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int sweep [10] = '{112, 167, 168, 279, 280, 336, 392, 504, 560, 672};
        bit seen;
        rst_n = 1'b0; rearm = 1'b0; rx_in = 1'b1;
        repeat (4) @(negedge clk);
        chk(host_wait == 1'b1 && locked == 1'b0 && tx_out == 1'b1, "R1",
            "outputs in reset", {host_wait, locked, tx_out}, 3'b101);
        chk({div_hi, div_lo} == 16'd0, "R1", "divisor in reset", {div_hi, div_lo}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(host_wait == 1'b1 && locked == 1'b0, "R1", "outputs after reset",
            {host_wait, locked}, 2'b10);

        // R3: 15-clock glitch is dropped, 16 clocks are accepted (R4 clamp to 1)
        drive_low(15);
        quiet_watch(40, "R3");
        chk(locked == 1'b0 && host_wait == 1'b1, "R3", "no lock from glitch",
            {locked, host_wait}, 2'b01);
        drive_low(16);
        check_ack(16, 1'b0);
        chk({div_hi, div_lo} == 16'd1, "R4", "divisor clamped to 1", {div_hi, div_lo}, 1);

        // R10: a second low span after lock is ignored
        drive_low(7 * 50);
        quiet_watch(60, "R10");
        chk({div_hi, div_lo} == 16'd1 && host_wait == 1'b0 && locked == 1'b1, "R10",
            "state unchanged by later rx", {div_hi, div_lo, host_wait, locked}, 18'h4_0005 >> 0);

        // R2: sweep low spans, including both sides of each rounding boundary
        foreach (sweep[i]) begin
            do_rearm();
            drive_low(sweep[i]);
            check_ack(sweep[i], 1'b0);
        end

        // R9: rearm sampled on the very edge that ends the last stop bit
        do_rearm();
        drive_low(7 * 24);
        check_ack(7 * 24, 1'b1);

        // R9: abort a long reply whose divisor has a nonzero high byte
        do_rearm();
        drive_low(29400);
        wait_tx_fall(seen);
        chk(seen && {div_hi, div_lo} == 16'd263, "R2", "large divisor 263",
            {div_hi, div_lo}, 263);
        rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
        chk(tx_out == 1'b1 && locked == 1'b0 && host_wait == 1'b1, "R9",
            "reply aborted", {tx_out, locked, host_wait}, 3'b101);
        repeat (4) @(negedge clk);
        drive_low(7 * 32);
        check_ack(7 * 32, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule